// File: doc/BRIEF.md
# Short-Format Branch Target Unit

This block resolves 16-bit branch instructions that carry an 8-bit relative displacement. For each accepted instruction it works out the address of the next instruction and whether the branch is taken. The four recognised forms are an unconditional jump, a subroutine call, a jump taken when data register 15 is zero, and a jump taken when it is nonzero. The fetch stage presents the instruction word, its own PC, the current value of data register 15 and a format class. One cycle later the block returns the next PC with a taken flag and an illegal flag.

A call is handled in two phases. The block first raises a request to the context save engine, carrying the caller's PC and the instruction length. It keeps that request up until the engine reports completion, and only then releases the branch target. The block takes no new instruction while a call is pending.

Top module: `sbt_unit`

## Requirements
- R1: After reset, `res_valid_o` and `call_req_o` are 0 and `ready_o` is 1.
- R2: The displacement is `instr_i[15:8]` and the major opcode is `instr_i[7:0]` (0x3C jump, 0x5C call, 0x6E jump-if-zero, 0xEE jump-if-nonzero). A taken target is `pc_i` plus twice the displacement, sign-extended from its bit 7, modulo 2^32. A jump is always taken.
- R3: Jump-if-zero is taken exactly when `d15_i` is zero.
- R4: Jump-if-nonzero is taken exactly when `d15_i` is nonzero.
- R5: A branch that is not taken gives `next_pc_o` = `pc_i` + 2 and `taken_o` = 0.
- R6: An instruction is accepted on a rising edge where `in_valid_i` and `ready_o` are 1 and `in_class_i` = 2'b01. For every form except a call, `res_valid_o` is 1 for exactly the one cycle that follows acceptance.
- R7: In the cycle after a call is accepted, `call_req_o` rises, with `call_pc_o` = the call's `pc_i` and `call_size_o` = 2. Both the request and `call_pc_o` hold until an edge where `call_done_i` is 1.
- R8: In the cycle after an edge where both `call_req_o` and `call_done_i` are 1, `res_valid_o` = 1, `taken_o` = 1, `next_pc_o` = the call target, and `call_req_o` = 0. No result appears while the request is up.
- R9: `ready_o` is 0 while a call is pending. An instruction offered during that time produces no result.
- R10: An opcode outside the four gives `illegal_o` = 1, `taken_o` = 0 and `next_pc_o` = `pc_i` + 2.
- R11: An input whose `in_class_i` is not 2'b01 produces no result and no call request. The same holds for `call_done_i` when no request is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction presented |
| in_class_i | input | 2 | Format class; 2'b01 marks a short branch |
| instr_i | input | 16 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| d15_i | input | 32 | Current value of data register 15 |
| call_done_i | input | 1 | Context save engine has finished |
| ready_o | output | 1 | Block can accept an instruction |
| res_valid_o | output | 1 | Result outputs are valid this cycle |
| next_pc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Branch was taken |
| illegal_o | output | 1 | Opcode was not a recognised branch |
| call_req_o | output | 1 | Context save request |
| call_pc_o | output | 32 | PC of the call, passed to the save engine |
| call_size_o | output | 4 | Instruction length in bytes |

## Verification
Most internal faults show up at the result one cycle after acceptance. A wrong sign extension or scale moves `next_pc_o` by a multiple of two. An inverted zero test flips `taken_o` and makes `next_pc_o` fall back to PC + 2. Faults in call sequencing show up over several cycles instead: a dropped request, a `call_pc_o` that drifts during the wait, a result that appears before completion, or an instruction accepted while one is pending. The scoreboard reports any of these at the first cycle where a result is missing, unexpected or wrong.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

   // Decoded branch form; BR_BAD marks an unknown opcode
   typedef enum logic [2:0] {
      BR_BAD  = 3'd0,
      BR_JMP  = 3'd1,
      BR_CALL = 3'd2,
      BR_JZ   = 3'd3,
      BR_JNZ  = 3'd4
   } br_kind_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_WAIT = 1'b1
   } seq_state_e;

   localparam logic [1:0] CLS_SHORT_BR = 2'b01;

endpackage

// File: rtl/sbt_decode.sv
module sbt_decode
   import sbt_pkg::*;
#(
   parameter int          OPC_W    = 8,
   parameter logic [7:0]  OPC_JMP  = 8'h3C,
   parameter logic [7:0]  OPC_CALL = 8'h5C,
   parameter logic [7:0]  OPC_JZ   = 8'h6E,
   parameter logic [7:0]  OPC_JNZ  = 8'hEE
) (
   input  logic [OPC_W-1:0] opc_i,
   output br_kind_e         kind_o
);

   always_comb begin
      if (opc_i == OPC_W'(OPC_JMP))       kind_o = BR_JMP;
      else if (opc_i == OPC_W'(OPC_CALL)) kind_o = BR_CALL;
      else if (opc_i == OPC_W'(OPC_JZ))   kind_o = BR_JZ;
      else if (opc_i == OPC_W'(OPC_JNZ))  kind_o = BR_JNZ;
      else                                kind_o = BR_BAD;
   end

endmodule

// File: rtl/sbt_target.sv
module sbt_target #(
   parameter int PC_W       = 32,
   parameter int DISP_W     = 8,
   parameter int SCALE_LOG2 = 1,
   parameter int INSN_BYTES = 2
) (
   input  logic [PC_W-1:0]   pc_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [PC_W-1:0]   jump_pc_o,
   output logic [PC_W-1:0]   fall_pc_o
);

   localparam int EXT_W = PC_W - DISP_W - SCALE_LOG2;

   logic [PC_W-1:0] offs;

   generate
      if (SCALE_LOG2 > 0) begin : g_scaled
         assign offs = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, {SCALE_LOG2{1'b0}}};
      end else begin : g_unscaled
         assign offs = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
      end
   endgenerate

   assign jump_pc_o = pc_i + offs;
   assign fall_pc_o = pc_i + PC_W'(INSN_BYTES);

endmodule

// File: rtl/sbt_cond.sv
module sbt_cond
   import sbt_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit ZERO_TREE = 1'b1
) (
   input  logic [DATA_W-1:0] d15_i,
   input  br_kind_e          kind_i,
   output logic              take_o
);

   logic is_zero;

   generate
      if (ZERO_TREE) begin : g_tree
         assign is_zero = ~|d15_i;
      end else begin : g_cmp
         assign is_zero = (d15_i == '0);
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         BR_JMP, BR_CALL: take_o = 1'b1;
         BR_JZ:           take_o = is_zero;
         BR_JNZ:          take_o = !is_zero;
         default:         take_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/sbt_seq.sv
module sbt_seq
   import sbt_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int SIZE_W     = 4,
   parameter int INSN_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  br_kind_e          kind_i,
   input  logic              take_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [PC_W-1:0]   jump_pc_i,
   input  logic [PC_W-1:0]   fall_pc_i,
   input  logic              call_done_i,
   output logic              ready_o,
   output logic              res_valid_o,
   output logic [PC_W-1:0]   next_pc_o,
   output logic              taken_o,
   output logic              illegal_o,
   output logic              call_req_o,
   output logic [PC_W-1:0]   call_pc_o,
   output logic [SIZE_W-1:0] call_size_o
);

   seq_state_e      state_q;
   logic [PC_W-1:0] pend_pc_q;

   assign ready_o     = (state_q == SQ_IDLE);
   assign call_size_o = SIZE_W'(INSN_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SQ_IDLE;
         pend_pc_q   <= '0;
         res_valid_o <= 1'b0;
         next_pc_o   <= '0;
         taken_o     <= 1'b0;
         illegal_o   <= 1'b0;
         call_req_o  <= 1'b0;
         call_pc_o   <= '0;
      end else begin
         res_valid_o <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (accept_i) begin
                  if (kind_i == BR_CALL) begin
                     state_q    <= SQ_WAIT;
                     call_req_o <= 1'b1;
                     call_pc_o  <= pc_i;
                     pend_pc_q  <= jump_pc_i;
                  end else begin
                     res_valid_o <= 1'b1;
                     taken_o     <= take_i;
                     illegal_o   <= (kind_i == BR_BAD);
                     next_pc_o   <= take_i ? jump_pc_i : fall_pc_i;
                  end
               end
            end
            SQ_WAIT: begin
               if (call_done_i) begin
                  state_q     <= SQ_IDLE;
                  call_req_o  <= 1'b0;
                  res_valid_o <= 1'b1;
                  taken_o     <= 1'b1;
                  illegal_o   <= 1'b0;
                  next_pc_o   <= pend_pc_q;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sbt_unit.sv
module sbt_unit
   import sbt_pkg::*;
#(
   parameter int          PC_W       = 32,
   parameter int          DATA_W     = 32,
   parameter int          INSN_W     = 16,
   parameter int          DISP_W     = 8,
   parameter int          DISP_LSB   = 8,
   parameter int          OPC_W      = 8,
   parameter int          SCALE_LOG2 = 1,
   parameter int          INSN_BYTES = 2,
   parameter int          SIZE_W     = 4,
   parameter bit          ZERO_TREE  = 1'b1,
   parameter logic [7:0]  OPC_JMP    = 8'h3C,
   parameter logic [7:0]  OPC_CALL   = 8'h5C,
   parameter logic [7:0]  OPC_JZ     = 8'h6E,
   parameter logic [7:0]  OPC_JNZ    = 8'hEE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid_i,
   input  logic [1:0]        in_class_i,
   input  logic [INSN_W-1:0] instr_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [DATA_W-1:0] d15_i,
   input  logic              call_done_i,
   output logic              ready_o,
   output logic              res_valid_o,
   output logic [PC_W-1:0]   next_pc_o,
   output logic              taken_o,
   output logic              illegal_o,
   output logic              call_req_o,
   output logic [PC_W-1:0]   call_pc_o,
   output logic [SIZE_W-1:0] call_size_o
);

   // Elaboration-time parameter checks
   generate
      if (DISP_LSB + DISP_W > INSN_W) begin : g_bad_disp
         $error("displacement field exceeds instruction width");
      end
      if (OPC_W > DISP_LSB || OPC_W > 8) begin : g_bad_opc
         $error("opcode field overlaps displacement or exceeds 8 bits");
      end
      if (PC_W <= DISP_W + SCALE_LOG2) begin : g_bad_pc
         $error("PC too narrow for scaled displacement");
      end
      if (INSN_BYTES >= (1 << SIZE_W)) begin : g_bad_size
         $error("instruction size does not fit size output");
      end
   endgenerate

   br_kind_e        kind;
   logic            take;
   logic            accept;
   logic [PC_W-1:0] jump_pc;
   logic [PC_W-1:0] fall_pc;

   assign accept = in_valid_i && ready_o && (in_class_i == CLS_SHORT_BR);

   sbt_decode #(
      .OPC_W(OPC_W), .OPC_JMP(OPC_JMP), .OPC_CALL(OPC_CALL),
      .OPC_JZ(OPC_JZ), .OPC_JNZ(OPC_JNZ)
   ) u_decode (
      .opc_i  (instr_i[OPC_W-1:0]),
      .kind_o (kind)
   );

   sbt_target #(
      .PC_W(PC_W), .DISP_W(DISP_W), .SCALE_LOG2(SCALE_LOG2), .INSN_BYTES(INSN_BYTES)
   ) u_target (
      .pc_i      (pc_i),
      .disp_i    (instr_i[DISP_LSB +: DISP_W]),
      .jump_pc_o (jump_pc),
      .fall_pc_o (fall_pc)
   );

   sbt_cond #(
      .DATA_W(DATA_W), .ZERO_TREE(ZERO_TREE)
   ) u_cond (
      .d15_i  (d15_i),
      .kind_i (kind),
      .take_o (take)
   );

   sbt_seq #(
      .PC_W(PC_W), .SIZE_W(SIZE_W), .INSN_BYTES(INSN_BYTES)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept_i    (accept),
      .kind_i      (kind),
      .take_i      (take),
      .pc_i        (pc_i),
      .jump_pc_i   (jump_pc),
      .fall_pc_i   (fall_pc),
      .call_done_i (call_done_i),
      .ready_o     (ready_o),
      .res_valid_o (res_valid_o),
      .next_pc_o   (next_pc_o),
      .taken_o     (taken_o),
      .illegal_o   (illegal_o),
      .call_req_o  (call_req_o),
      .call_pc_o   (call_pc_o),
      .call_size_o (call_size_o)
   );

endmodule

// File: rtl/sbt_unit_chk.sv
module sbt_unit_chk #(
   parameter int PC_W       = 32,
   parameter int INSN_BYTES = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] pc_i,
   input logic            ready_o,
   input logic            res_valid_o,
   input logic [PC_W-1:0] next_pc_o,
   input logic            taken_o,
   input logic            illegal_o,
   input logic            call_req_o,
   input logic            call_done_i,
   input logic [PC_W-1:0] call_pc_o
);

   // R7: a pending request and its PC hold until completion
   p_call_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o && !call_done_i |=> call_req_o && $stable(call_pc_o));

   // R8: completion releases a taken result and drops the request
   p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o && call_done_i |=> res_valid_o && taken_o && !call_req_o);

   // R8: no result while the request is up
   p_no_early_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> !res_valid_o);

   // R9: nothing accepted while a call is pending
   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      call_req_o |-> !ready_o);

   // R10: an illegal opcode is never taken
   p_illegal_nt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && illegal_o |-> !taken_o);

   // R5: a not-taken result falls through by one instruction
   p_fall_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o && !taken_o |-> next_pc_o == $past(pc_i) + PC_W'(INSN_BYTES));

endmodule

bind sbt_unit sbt_unit_chk #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pc_i        (pc_i),
   .ready_o     (ready_o),
   .res_valid_o (res_valid_o),
   .next_pc_o   (next_pc_o),
   .taken_o     (taken_o),
   .illegal_o   (illegal_o),
   .call_req_o  (call_req_o),
   .call_done_i (call_done_i),
   .call_pc_o   (call_pc_o)
);

// File: tb/sbt_unit_test.sv
module sbt_unit_test;

   localparam logic [7:0] OP_J = 8'h3C, OP_CALL = 8'h5C, OP_JZ = 8'h6E, OP_JNZ = 8'hEE;

   typedef struct {
      logic [31:0] pc;
      logic        tk;
      logic        il;
      int          rq;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_class = 2'b00;
   logic [15:0] instr = '0;
   logic [31:0] pc = '0;
   logic [31:0] d15 = '0;
   logic        call_done = 1'b0;
   logic        ready, res_valid, taken, illegal, call_req;
   logic [31:0] next_pc, call_pc;
   logic [3:0]  call_size;

   int checks = 0;
   int fails  = 0;
   exp_t q[$];

   always #4 clk = ~clk;

   sbt_unit uut (
      .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_class_i(in_class),
      .instr_i(instr), .pc_i(pc), .d15_i(d15), .call_done_i(call_done),
      .ready_o(ready), .res_valid_o(res_valid), .next_pc_o(next_pc),
      .taken_o(taken), .illegal_o(illegal), .call_req_o(call_req),
      .call_pc_o(call_pc), .call_size_o(call_size)
   );

   function automatic logic [31:0] tgt(input logic [31:0] p, input logic [7:0] d);
      logic signed [31:0] sd;
      sd = 32'(signed'(d));
      return p + 32'(sd * 2);
   endfunction

   task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", rq, act, expv);
      end
   endtask

   // Monitor: pops the scoreboard whenever a result appears
   always @(posedge clk) begin
      #2;
      if (rst_n && res_valid) begin
         if (q.size() == 0) begin
            check(1'b0, "R9/R11 unexpected result", next_pc, 32'hx);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(next_pc == e.pc, $sformatf("R%0d next_pc", e.rq), next_pc, e.pc);
            check(taken == e.tk, $sformatf("R%0d taken", e.rq), 32'(taken), 32'(e.tk));
            check(illegal == e.il, $sformatf("R%0d illegal", e.rq), 32'(illegal), 32'(e.il));
         end
      end
   end

   task automatic send(input logic [1:0] cls, input logic [7:0] op, input logic [7:0] d,
                       input logic [31:0] p, input logic [31:0] r15, input bit push,
                       input logic [31:0] epc, input logic etk, input logic eil, input int rq);
      @(negedge clk);
      in_valid = 1'b1; in_class = cls; instr = {d, op}; pc = p; d15 = r15;
      if (push) q.push_back('{pc: epc, tk: etk, il: eil, rq: rq});
      @(negedge clk);
      in_valid = 1'b0;
      // R6: single-cycle pulse; next cycle must be quiet again
      @(negedge clk);
      check(res_valid == 1'b0, "R6 pulse length", 32'(res_valid), 32'd0);
   endtask

   task automatic do_call(input logic [7:0] d, input logic [31:0] p, input int waits);
      @(negedge clk);
      in_valid = 1'b1; in_class = 2'b01; instr = {d, OP_CALL}; pc = p; d15 = 32'h1;
      @(negedge clk);
      in_valid = 1'b0; pc = 32'hDEAD_0000;
      check(call_req == 1'b1, "R7 call_req raised", 32'(call_req), 32'd1);
      check(call_pc == p, "R7 call_pc", call_pc, p);
      check(call_size == 4'd2, "R7 call_size", 32'(call_size), 32'd2);
      check(ready == 1'b0, "R9 busy", 32'(ready), 32'd0);
      for (int i = 0; i < waits; i++) begin
         // R9: offer an instruction that must be ignored
         in_valid = (i == 0); in_class = 2'b01; instr = {8'h04, OP_J};
         @(negedge clk);
         in_valid = 1'b0;
         check(call_req == 1'b1, "R7 request held", 32'(call_req), 32'd1);
         check(call_pc == p, "R7 call_pc stable", call_pc, p);
      end
      call_done = 1'b1;
      q.push_back('{pc: tgt(p, d), tk: 1'b1, il: 1'b0, rq: 8});
      @(negedge clk);
      call_done = 1'b0;
      check(call_req == 1'b0, "R8 request dropped", 32'(call_req), 32'd0);
      check(ready == 1'b1, "R9 ready again", 32'(ready), 32'd1);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #(8 * 200000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(res_valid == 1'b0, "R1 res_valid", 32'(res_valid), 32'd0);
      check(call_req == 1'b0, "R1 call_req", 32'(call_req), 32'd0);
      check(ready == 1'b1, "R1 ready", 32'(ready), 32'd1);
      rst_n = 1'b1;

      // R2: jumps with positive, negative, extreme and wrapping displacements
      send(2'b01, OP_J, 8'h05, 32'h1000, 32'h7, 1, 32'h100A, 1, 0, 2);
      send(2'b01, OP_J, 8'h80, 32'h1000, 32'h0, 1, 32'h0F00, 1, 0, 2);
      send(2'b01, OP_J, 8'hFF, 32'h2000, 32'h0, 1, 32'h1FFE, 1, 0, 2);
      send(2'b01, OP_J, 8'h7F, 32'h2000, 32'h0, 1, 32'h20FE, 1, 0, 2);
      send(2'b01, OP_J, 8'h80, 32'h0010, 32'h0, 1, 32'hFFFF_FF10, 1, 0, 2);
      // R3: jump-if-zero
      send(2'b01, OP_JZ, 8'h10, 32'h3000, 32'h0, 1, 32'h3020, 1, 0, 3);
      send(2'b01, OP_JZ, 8'h10, 32'h3000, 32'h1, 1, 32'h3002, 0, 0, 5);
      send(2'b01, OP_JZ, 8'h10, 32'h3000, 32'h8000_0000, 1, 32'h3002, 0, 0, 3);
      // R4: jump-if-nonzero
      send(2'b01, OP_JNZ, 8'hF0, 32'h3400, 32'h0, 1, 32'h3402, 0, 0, 5);
      send(2'b01, OP_JNZ, 8'hF0, 32'h3400, 32'hFFFF_FFFF, 1, 32'h33E0, 1, 0, 4);
      // R10: unrecognised opcodes
      send(2'b01, 8'h00, 8'h40, 32'h5500, 32'h0, 1, 32'h5502, 0, 1, 10);
      send(2'b01, 8'h3D, 8'h40, 32'hFFFF_FFFE, 32'h0, 1, 32'h0000_0000, 0, 1, 10);
      // R11: other classes and stray completion are ignored
      send(2'b10, OP_J, 8'h05, 32'h6000, 32'h0, 0, 32'h0, 0, 0, 11);
      send(2'b00, OP_JZ, 8'h05, 32'h6000, 32'h0, 0, 32'h0, 0, 0, 11);
      @(negedge clk); call_done = 1'b1;
      @(negedge clk); call_done = 1'b0;
      check(call_req == 1'b0 && res_valid == 1'b0, "R11 stray done", 32'(res_valid), 32'd0);
      // R7 R8 R9: calls with long and zero waits
      do_call(8'h20, 32'h4000, 3);
      do_call(8'hC0, 32'h5000, 0);
      // back to normal after a call
      send(2'b01, OP_J, 8'h01, 32'h7000, 32'h0, 1, 32'h7002, 1, 0, 2);
      repeat (3) @(negedge clk);
      check(q.size() == 0, "R6/R8 results outstanding", 32'(q.size()), 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule